// File: doc/BRIEF.md
# Interval and Free-Run Counter Channel

This block is one 32-bit counter channel driven from a small synchronous register bus. Software loads a compare value and picks one of two modes. It then starts the channel by writing a start trigger and halts it by writing a halt trigger. A read-only status bit shows whether the channel is counting. The block has one interrupt output.

In interval mode the counter takes the compare value at start and counts down by one each clock. When it reaches zero it reloads and pulses the interrupt, so the interrupt repeats every compare-plus-one clocks. In free-run mode the counter starts at zero and counts up, wrapping at its full width. Software can read it as a time base. A one-clock interrupt pulse is raised each time the count equals the compare value. Software uses this as a one-shot by halting the channel after the first pulse.

The compare and mode registers can be written at any time. The running channel works from copies taken at the start trigger, so a new setting takes effect only at the next start.

Top module: `cyc_timer`

## Requirements
- R1: After a synchronous active-low reset, the compare, count, status and mode registers all read 0, and the interrupt is low.
- R2: The register offsets are compare 0x00 (read/write, 32 bits), count 0x04 (read-only), status 0x10 (bit 0 = running), start trigger 0x14, halt trigger 0x18 and mode 0x20. Mode bit 1 selects 0 = interval and 1 = free-run. Other mode bits, both trigger registers and unused offsets read as 0.
- R3: In interval mode, a start write with data bit 0 = 1 sets the status bit and loads the count with the compare value on the same edge. The count then drops by one on each following clock.
- R4: In interval mode, on the clock after the count reads 0, the count reloads the compare value and the interrupt is high for exactly that one clock. The result is one pulse every compare+1 clocks.
- R5: In free-run mode, a start loads the count with 0. The count then rises by one each clock and wraps from all-ones to 0.
- R6: In free-run mode, the interrupt is high for one clock on the clock after the count equals the compare value, and counting continues. This repeats after each wrap.
- R7: A halt write with data bit 0 = 1 while running clears the status bit and freezes the count at its current value. No interrupt is raised while halted.
- R8: A start write while running does not reload the count. A halt write while idle has no effect. A trigger write with data bit 0 = 0 is ignored.
- R9: Compare and mode writes made while running read back at once but leave the current run unchanged. They take effect at the next start.
- R10: If a halt lands on the same edge as an interval reload or a free-run match, the halt wins and no interrupt pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
Two events can fall on the same edge: a halt write, and either the interval reload at zero or the free-run compare match. The bench places the halt write exactly on the edge where the pulse would otherwise be registered, once in each mode. It then judges at the ports that the interrupt stays low, the status reads 0 and the count stays frozen. A second coincidence is a compare or mode write during a run, which lands near a reload. Here the bench checks that the pulse spacing still follows the old compare value and that the new setting governs the next start.

// File: rtl/cyc_timer_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets and mode encoding for the counter channel.
package cyc_timer_pkg;
    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 32;
    localparam int MODE_BIT = 1;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_GO   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_HALT = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_MODE = 6'h20;

    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_FREERUN  = 1'b1
    } tmode_e;
endpackage

// File: rtl/cyc_timer_regs.sv
`timescale 1ns/1ps
// Module: register file and bus decode.
// Holds the programmed compare value and mode, turns trigger writes into
// one-cycle requests, and muxes read data. Assumes CNT_W <= DATA_W and a
// single-cycle write strobe.
module cyc_timer_regs
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              running,
    output logic [CNT_W-1:0]  cmp_cfg,
    output tmode_e            mode_cfg,
    output logic              go_req,
    output logic              halt_req,
    output logic [DATA_W-1:0] rd_data
);
    logic sel_cmp;
    logic sel_mode;

    // Decode which register a write targets.
    always_comb begin
        sel_cmp  = wr_en && (addr == OFS_CMP);
        sel_mode = wr_en && (addr == OFS_MODE);
        go_req   = wr_en && (addr == OFS_GO)   && wr_data[0];
        halt_req = wr_en && (addr == OFS_HALT) && wr_data[0];
    end

    // Store programmed compare and mode; the core copies them at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_cfg  <= '0;
            mode_cfg <= MODE_INTERVAL;
        end else begin
            if (sel_cmp)  cmp_cfg  <= wr_data[CNT_W-1:0];
            if (sel_mode) mode_cfg <= tmode_e'(wr_data[MODE_BIT]);
        end
    end

    // Read mux; triggers and unused offsets return zero.
    always_comb begin
        rd_data = '0;
        case (addr)
            OFS_CMP:  rd_data = DATA_W'(cmp_cfg);
            OFS_CNT:  rd_data = DATA_W'(cnt_val);
            OFS_STAT: rd_data = DATA_W'(running);
            OFS_MODE: rd_data[MODE_BIT] = mode_cfg;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cyc_timer_step.sv
`timescale 1ns/1ps
// Module: next-count and event logic for one running clock.
// Pure combinational. Interval mode counts down and reloads at zero;
// free-run counts up with natural wrap. 'hit' marks the event edge.
module cyc_timer_step
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] cnt_cur,
    input  logic [CNT_W-1:0] cmp_act,
    input  tmode_e           mode_act,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Pick next count and event according to active mode.
    always_comb begin
        if (mode_act == MODE_INTERVAL) begin
            hit     = (cnt_cur == '0);
            cnt_nxt = hit ? cmp_act : (cnt_cur - ONE);
        end else begin
            hit     = (cnt_cur == cmp_act);
            cnt_nxt = cnt_cur + ONE;
        end
    end
endmodule

// File: rtl/cyc_timer_core.sv
`timescale 1ns/1ps
// Module: counter engine.
// Runs from copies of compare and mode taken at start, so programming
// changes while running wait for the next start. A halt outranks a
// same-edge event. Assumes go_req and halt_req are never high together.
module cyc_timer_core
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_req,
    input  logic             halt_req,
    input  logic [CNT_W-1:0] cmp_cfg,
    input  tmode_e           mode_cfg,
    output logic             running,
    output logic [CNT_W-1:0] cnt_q,
    output tmode_e           mode_act,
    output logic             irq
);
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit;
    logic             start_ok;
    logic             stop_ok;

    // Qualify triggers by current state.
    always_comb begin
        start_ok = go_req && !running;
        stop_ok  = halt_req && running;
    end

    cyc_timer_step #(.CNT_W(CNT_W)) u_step (
        .cnt_cur (cnt_q),
        .cmp_act (cmp_act),
        .mode_act(mode_act),
        .cnt_nxt (cnt_nxt),
        .hit     (hit)
    );

    // Run state, active copies, count and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cnt_q    <= '0;
            cmp_act  <= '0;
            mode_act <= MODE_INTERVAL;
            irq      <= 1'b0;
        end else if (stop_ok) begin
            running <= 1'b0;
            irq     <= 1'b0;
        end else if (start_ok) begin
            running  <= 1'b1;
            cmp_act  <= cmp_cfg;
            mode_act <= mode_cfg;
            cnt_q    <= (mode_cfg == MODE_INTERVAL) ? cmp_cfg : '0;
            irq      <= 1'b0;
        end else if (running) begin
            cnt_q <= cnt_nxt;
            irq   <= hit;
        end else begin
            irq <= 1'b0;
        end
    end
endmodule

// File: rtl/cyc_timer.sv
`timescale 1ns/1ps
// Module: top of the counter channel.
// Joins the register file and the counter engine. Bus reads are
// combinational; writes take effect at the clock edge they are sampled on.
module cyc_timer
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] cmp_cfg_w;
    tmode_e           mode_cfg_w;
    logic             go_w;
    logic             halt_w;
    logic             run_w;
    logic [CNT_W-1:0] cnt_w;
    tmode_e           mode_act_w;

    cyc_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr_en   (bus_wr),
        .wr_data (bus_wdata),
        .cnt_val (cnt_w),
        .running (run_w),
        .cmp_cfg (cmp_cfg_w),
        .mode_cfg(mode_cfg_w),
        .go_req  (go_w),
        .halt_req(halt_w),
        .rd_data (bus_rdata)
    );

    cyc_timer_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_req  (go_w),
        .halt_req(halt_w),
        .cmp_cfg (cmp_cfg_w),
        .mode_cfg(mode_cfg_w),
        .running (run_w),
        .cnt_q   (cnt_w),
        .mode_act(mode_act_w),
        .irq     (irq)
    );
endmodule

// File: rtl/cyc_timer_chk.sv
`timescale 1ns/1ps
// Module: property checker for the counter channel, bound to the top.
// Watches the bus, run state, count and interrupt over time.
module cyc_timer_chk
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              run_w,
    input logic [CNT_W-1:0]  cnt_w,
    input tmode_e            mode_act_w,
    input logic              irq
);
    logic go_hit;
    logic halt_hit;

    // Trigger writes as seen on the bus.
    always_comb begin
        go_hit   = bus_wr && (bus_addr == OFS_GO)   && bus_wdata[0];
        halt_hit = bus_wr && (bus_addr == OFS_HALT) && bus_wdata[0];
    end

    AST_IRQ_LOW_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R1

    AST_START_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        go_hit && !run_w |=> run_w); // R3

    AST_INTERVAL_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        run_w && (mode_act_w == MODE_INTERVAL) && (cnt_w != '0) && !halt_hit
        |=> cnt_w == CNT_W'($past(cnt_w) - CNT_W'(1))); // R3

    AST_IRQ_ONLY_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> run_w && $past(run_w)); // R4

    AST_FREERUN_COUNTS_UP: assert property (@(posedge clk) disable iff (!rst_n)
        run_w && (mode_act_w == MODE_FREERUN) && !halt_hit
        |=> cnt_w == CNT_W'($past(cnt_w) + CNT_W'(1))); // R5

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        halt_hit && run_w |=> !run_w && !irq && $stable(cnt_w)); // R10

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !run_w && !go_hit |=> $stable(cnt_w) && !irq && !run_w); // R7

    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        go_hit && run_w |=> run_w); // R8
endmodule

bind cyc_timer cyc_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .run_w     (run_w),
    .cnt_w     (cnt_w),
    .mode_act_w(mode_act_w),
    .irq       (irq)
);

// File: tb/cyc_timer_test.sv
`timescale 1ns/1ps
// Bench: table-driven register checks, then directed timing and corner tests.
module cyc_timer_test;
    localparam logic [5:0] A_CMP  = 6'h00;
    localparam logic [5:0] A_CNT  = 6'h04;
    localparam logic [5:0] A_STAT = 6'h10;
    localparam logic [5:0] A_GO   = 6'h14;
    localparam logic [5:0] A_HALT = 6'h18;
    localparam logic [5:0] A_MODE = 6'h20;
    localparam logic [1:0] K_WR   = 2'd0;
    localparam logic [1:0] K_RD   = 2'd1;
    localparam int NV = 15;

    // {kind, addr, data}: write data, or expected read data.
    localparam logic [39:0] VEC [NV] = '{
        {K_WR, A_CMP,  32'h1234_5678},
        {K_RD, A_CMP,  32'h1234_5678},
        {K_WR, A_MODE, 32'h0000_00FF},
        {K_RD, A_MODE, 32'h0000_0002},
        {K_WR, A_MODE, 32'h0000_0000},
        {K_RD, A_MODE, 32'h0000_0000},
        {K_RD, A_GO,   32'h0000_0000},
        {K_RD, A_HALT, 32'h0000_0000},
        {K_RD, 6'h08,  32'h0000_0000},
        {K_WR, A_GO,   32'h0000_0000},
        {K_RD, A_STAT, 32'h0000_0000},
        {K_WR, A_GO,   32'h0000_0001},
        {K_RD, A_STAT, 32'h0000_0001},
        {K_WR, A_HALT, 32'h0000_0001},
        {K_RD, A_STAT, 32'h0000_0000}
    };
    localparam string TAG [NV] = '{"R2", "R2", "R2", "R2", "R2", "R2", "R2",
                                   "R2", "R2", "R8", "R8", "R3", "R3", "R7", "R7"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] n_rdata;
    logic        irq;
    logic        n_irq;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] held;

    always #5 clk = ~clk;

    cyc_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Narrow copy on the same bus, used to reach the wrap point quickly.
    cyc_timer #(.CNT_W(8)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(n_rdata), .irq(n_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 chk(req, bus_rdata, exp);
    endtask

    // Peek at a register in the current half cycle without waiting.
    task automatic peek(input string req, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        peek("R1", A_CMP, 32'h0);
        peek("R1", A_CNT, 32'h0);
        peek("R1", A_STAT, 32'h0);
        peek("R1", A_MODE, 32'h0);
        chk("R1", {31'h0, irq}, 32'h0);
        chk("R1", n_rdata, 32'h0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][39:38] == K_WR) wr(VEC[v][37:32], VEC[v][31:0]);
            else rd(TAG[v], VEC[v][37:32], VEC[v][31:0]);
        end

        // R3/R4: interval period with compare 4
        wr(A_CMP, 32'd4);
        wr(A_MODE, 32'd0);
        wr(A_GO, 32'd1);
        peek("R3", A_CNT, 32'd4);
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            peek("R4", A_CNT, 32'(4 - (i % 5)));
            chk("R4", {31'h0, irq}, {31'h0, (i % 5) == 0});
        end

        // R7: halt freezes count, status clears, halt when idle ignored (R8)
        wr(A_HALT, 32'd1);
        bus_addr = A_CNT;
        #1 held = bus_rdata;
        peek("R7", A_STAT, 32'd0);
        wr(A_HALT, 32'd1);
        repeat (3) begin
            @(negedge clk);
            chk("R7", {31'h0, irq}, 32'h0);
        end
        peek("R8", A_CNT, held);
        peek("R8", A_STAT, 32'd0);

        // R8: restart while running does not reload; halt with bit0=0 ignored
        wr(A_GO, 32'd1);
        wr(A_GO, 32'd1);
        peek("R8", A_CNT, 32'd2);
        wr(A_HALT, 32'd0);
        peek("R8", A_STAT, 32'd1);
        wr(A_HALT, 32'd1);

        // R9: writes while running wait for next start
        wr(A_GO, 32'd1);
        wr(A_CMP, 32'd9);
        wr(A_MODE, 32'd2);
        peek("R9", A_CMP, 32'd9);
        peek("R9", A_MODE, 32'd2);
        for (int i = 5; i <= 10; i++) begin
            @(negedge clk);
            peek("R9", A_CNT, 32'(4 - (i % 5)));
            chk("R9", {31'h0, irq}, {31'h0, (i % 5) == 0});
        end
        wr(A_HALT, 32'd1);
        wr(A_GO, 32'd1);
        // R5/R6: now free-run with compare 9
        peek("R5", A_CNT, 32'd0);
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            peek("R5", A_CNT, 32'(i));
            chk("R6", {31'h0, irq}, {31'h0, i == 10});
        end
        wr(A_HALT, 32'd1);

        // R10: halt on the interval reload edge
        wr(A_CMP, 32'd2);
        wr(A_MODE, 32'd0);
        wr(A_GO, 32'd1);
        @(negedge clk);
        wr(A_HALT, 32'd1);
        chk("R10", {31'h0, irq}, 32'h0);
        peek("R10", A_STAT, 32'd0);
        peek("R10", A_CNT, 32'd0);
        @(negedge clk);
        chk("R10", {31'h0, irq}, 32'h0);

        // R10: halt on the free-run match edge
        wr(A_CMP, 32'd1);
        wr(A_MODE, 32'd2);
        wr(A_GO, 32'd1);
        wr(A_HALT, 32'd1);
        chk("R10", {31'h0, irq}, 32'h0);
        peek("R10", A_CNT, 32'd1);
        @(negedge clk);
        chk("R10", {31'h0, irq}, 32'h0);

        // R5/R6: wrap on the narrow copy, free-run compare 2
        wr(A_CMP, 32'd2);
        wr(A_GO, 32'd1);
        bus_addr = A_CNT;
        #1 chk("R5", n_rdata, 32'd0);
        for (int i = 1; i <= 260; i++) begin
            @(negedge clk);
            #1;
            chk("R5", n_rdata, 32'(i % 256));
            chk("R6", {31'h0, n_irq}, {31'h0, (i % 256) == 3});
        end
        wr(A_HALT, 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule